// File: doc/BRIEF.md
# Mode-Aware Eight-Pin GPIO Port Controller

This block controls one eight-pin general-purpose port for a small CPU. Software reaches it over a plain single-cycle register bus. There are four registers. The direction register can only be written. The output-data register and the pull-up register can be read and written. The pin-level register can only be read. In I/O mode each pin drives the output-data bit when its direction bit is 1 and acts as an input when the bit is 0. A pull-up is switched on only for input pins whose pull-up bit is set.

An operating-mode code and a bus-width select together decide who owns the pins. Mode codes 1, 2, 4, 5 and 6 with the 16-bit width selected give the pins to the external bus controller as data lines. In that case the register contents stay as they were but no longer affect the pins. All other combinations keep the port in I/O mode.

Two reset kinds and two standby kinds act differently on the register contents. A power-on reset and hardware standby clear the registers. A manual reset and software standby keep them.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Power-on reset (`rst_por_n` low, asynchronous) clears the direction, output-data and pull-up registers to 0x00. After it, every pin output enable is 0 and reads of the data and pull-up registers return 0x00.
- R2: A read of the direction register address (0xFEBD) always returns 0xFF, whatever has been written there.
- R3: In I/O mode, `pin_oe[i]` equals direction bit i and `pin_out` equals the output-data register. A write takes effect on the clock edge that accepts it.
- R4: The output-data register (0xFF6D) and the pull-up register (0xFF74) read back the last value written to them.
- R5: A read of the pin-level register (0xFF5D) returns `pin_in` as sampled through two flops. A change of `pin_in` becomes visible after exactly the second rising edge that follows it.
- R6: `pin_pu[i]` is 1 only when the port is in I/O mode, pull-up bit i is 1 and direction bit i is 0.
- R7: Bus mode holds when `bus16` is 1 and `mode` is 1, 2, 4, 5 or 6. In bus mode `pin_out` equals `xbus_dout`, every `pin_oe` bit equals `xbus_oe`, `pin_pu` is 0x00 and `xbus_din` equals `pin_in`. Outside bus mode `xbus_din` is 0x00.
- R8: With `mode` set to 0, 3 or 7, the port stays in I/O mode whatever the value of `bus16`.
- R9: While `stby_hw` is high, each clock edge clears the direction, output-data and pull-up registers to 0x00.
- R10: While `rst_manual` or `stby_sw` is high, the registers keep their contents and register writes are ignored.
- R11: A write to the pin-level register has no effect. A read of any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_manual | input | 1 | Manual reset; registers kept, writes blocked |
| stby_hw | input | 1 | Hardware standby; clears the registers |
| stby_sw | input | 1 | Software standby; registers kept, writes blocked |
| mode | input | 3 | Operating-mode code |
| bus16 | input | 1 | 16-bit external data bus selected |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Register address (low 16 bits) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| xbus_dout | input | 8 | Bus controller data to drive on the pins |
| xbus_oe | input | 1 | Bus controller drive enable (write strobe) |
| xbus_din | output | 8 | Pin levels passed to the bus controller in bus mode |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |

## Verification
Some properties are checked by assertions on every cycle: a pull-up is never enabled on a driven pin or in bus mode, hardware standby leaves the registers cleared, a manual reset or software standby holds them unchanged, an accepted data write lands, and the pin-level path lags the pads by exactly two edges. Other behaviour shows up only in the bench's scenarios: the full mode and bus-width table, the fixed readback of the direction register, the lack of effect of writes during the hold conditions, and the cases where power-on reset and hardware standby clear the state in the middle of a run.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] ADR_DIR  = 16'hFEBD;
  localparam logic [ADDR_W-1:0] ADR_DATA = 16'hFF6D;
  localparam logic [ADDR_W-1:0] ADR_PINS = 16'hFF5D;
  localparam logic [ADDR_W-1:0] ADR_PULL = 16'hFF74;

  typedef struct packed {
    logic [PORT_W-1:0] dir;
    logic [PORT_W-1:0] data;
    logic [PORT_W-1:0] pull;
  } port_regs_t;

  // Mode codes in which the 16-bit bus width claims the pins.
  function automatic logic mode_allows_bus(input logic [2:0] m);
    case (m)
      3'd1, 3'd2, 3'd4, 3'd5, 3'd6: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_por_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_por_n) begin
      if (!rst_por_n) begin
        stage1[i] <= 1'b0;
        dout[i]   <= 1'b0;
      end else begin
        stage1[i] <= din[i];
        dout[i]   <= stage1[i];
      end
    end
  end

  // Edges seen since reset, saturating, for the latency check.
  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n)        edges <= 2'd0;
    else if (edges != 2'd2) edges <= edges + 2'd1;
  end

  a_r5_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_por_n)
    (edges == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              rst_manual,
  input  logic              stby_hw,
  input  logic              stby_sw,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  input  logic [PORT_W-1:0] pins_sync,
  output logic [PORT_W-1:0] reg_rdata,
  output port_regs_t        regs
);
  logic hold;
  logic wr_en;
  assign hold  = rst_manual | stby_sw;
  assign wr_en = reg_sel & reg_wr & ~hold;

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      regs <= '0;
    end else if (stby_hw) begin
      regs <= '0;
    end else if (wr_en) begin
      case (reg_addr)
        ADR_DIR:  regs.dir  <= reg_wdata;
        ADR_DATA: regs.data <= reg_wdata;
        ADR_PULL: regs.pull <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_wr) begin
      case (reg_addr)
        ADR_DIR:  reg_rdata = '1;
        ADR_DATA: reg_rdata = regs.data;
        ADR_PINS: reg_rdata = pins_sync;
        ADR_PULL: reg_rdata = regs.pull;
        default:  reg_rdata = '0;
      endcase
    end
  end

  a_r9_hw_standby_clears: assert property (@(posedge clk) disable iff (!rst_por_n)
    stby_hw |=> (regs == '0));
  a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_por_n)
    (hold && !stby_hw) |=> $stable(regs));
  a_r4_data_write_lands: assert property (@(posedge clk) disable iff (!rst_por_n)
    (wr_en && !stby_hw && reg_addr == ADR_DATA) |=> (regs.data == $past(reg_wdata)));
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
  parameter int W = 8
) (
  input  logic         bus_own,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] data,
  input  logic [W-1:0] pull,
  input  logic [W-1:0] xbus_dout,
  input  logic         xbus_oe,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] xbus_din,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (bus_own) begin
        pin_out[i]  = xbus_dout[i];
        pin_oe[i]   = xbus_oe;
        pin_pu[i]   = 1'b0;
        xbus_din[i] = pin_in[i];
      end else begin
        pin_out[i]  = data[i];
        pin_oe[i]   = dir[i];
        pin_pu[i]   = pull[i] & ~dir[i];
        xbus_din[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              rst_manual,
  input  logic              stby_hw,
  input  logic              stby_sw,
  input  logic [2:0]        mode,
  input  logic              bus16,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PORT_W-1:0] reg_wdata,
  output logic [PORT_W-1:0] reg_rdata,
  input  logic [PORT_W-1:0] xbus_dout,
  input  logic              xbus_oe,
  output logic [PORT_W-1:0] xbus_din,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_pu
);
  logic [PORT_W-1:0] pins_sync;
  port_regs_t        regs;
  logic              bus_own;

  assign bus_own = bus16 & mode_allows_bus(mode);

  gpio_port_sync #(.W(PORT_W)) i_sync (
    .clk(clk), .rst_por_n(rst_por_n), .din(pin_in), .dout(pins_sync)
  );

  gpio_port_regs i_regs (
    .clk(clk), .rst_por_n(rst_por_n), .rst_manual(rst_manual),
    .stby_hw(stby_hw), .stby_sw(stby_sw), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pins_sync(pins_sync),
    .reg_rdata(reg_rdata), .regs(regs)
  );

  gpio_port_mux #(.W(PORT_W)) i_mux (
    .bus_own(bus_own), .dir(regs.dir), .data(regs.data), .pull(regs.pull),
    .xbus_dout(xbus_dout), .xbus_oe(xbus_oe), .pin_in(pin_in),
    .xbus_din(xbus_din), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  a_r6_no_pull_on_driver: assert property (@(posedge clk) disable iff (!rst_por_n)
    (pin_pu & pin_oe) == '0);
  a_r7_no_pull_in_bus: assert property (@(posedge clk) disable iff (!rst_por_n)
    bus_own |-> (pin_pu == '0));
  a_r1_por_no_drive: assert property (@(posedge clk) disable iff (!rst_por_n)
    $rose(rst_por_n) |-> (pin_oe == '0 || bus_own));
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_por_n, rst_manual, stby_hw, stby_sw, bus16, reg_sel, reg_wr, xbus_oe;
  logic [2:0]  mode;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata, xbus_dout, xbus_din, pin_in, pin_out, pin_oe, pin_pu;

  gpio_port_ctrl i_gpio_port_ctrl (.*);

  localparam logic [15:0] A_DIR = 16'hFEBD, A_DATA = 16'hFF6D,
                          A_PINS = 16'hFF5D, A_PULL = 16'hFF74;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Fields: mode(3) bus16(1) dir(8) data(8) pull(8)
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {3'd3, 1'b0, 8'hF0, 8'hA5, 8'h0F},
    {3'd7, 1'b1, 8'h3C, 8'h5A, 8'hFF},
    {3'd1, 1'b0, 8'h81, 8'h7E, 8'hFF},
    {3'd2, 1'b1, 8'h81, 8'h7E, 8'hFF},
    {3'd4, 1'b1, 8'h00, 8'hFF, 8'hFF},
    {3'd5, 1'b0, 8'hFF, 8'h00, 8'hFF},
    {3'd6, 1'b1, 8'h55, 8'hAA, 8'hF0},
    {3'd0, 1'b1, 8'h0F, 8'h33, 8'hCC},
    {3'd3, 1'b1, 8'hAA, 8'h55, 8'h55}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_por_n = 1'b0; rst_manual = 1'b0; stby_hw = 1'b0; stby_sw = 1'b0;
    bus16 = 1'b0; mode = 3'd3; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0;
    reg_wdata = '0; xbus_oe = 1'b0; xbus_dout = '0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_por_n = 1'b1;

    // R1 reset state
    #1 check("R1 oe after por", pin_oe, 8'h00);
    rd(A_DATA, v); check("R1 data after por", v, 8'h00);
    rd(A_PULL, v); check("R1 pull after por", v, 8'h00);

    // R2 direction readback fixed
    wr(A_DIR, 8'h12);
    rd(A_DIR, v); check("R2 dir readback", v, 8'hFF);

    // Vector table: R3, R4, R6, R7, R8
    for (int k = 0; k < NV; k++) begin
      logic [2:0] m; logic b; logic [7:0] dd, dt, pl;
      logic busm;
      {m, b, dd, dt, pl} = VEC[k];
      wr(A_DIR, dd); wr(A_DATA, dt); wr(A_PULL, pl);
      @(negedge clk);
      mode = m; bus16 = b; xbus_dout = ~dt; xbus_oe = k[0]; pin_in = dt ^ 8'h0F;
      busm = b && (m == 3'd1 || m == 3'd2 || m == 3'd4 || m == 3'd5 || m == 3'd6);
      #1;
      if (busm) begin
        check("R7 bus out", pin_out, ~dt);
        check("R7 bus oe", pin_oe, k[0] ? 8'hFF : 8'h00);
        check("R7 bus pull off", pin_pu, 8'h00);
        check("R7 bus din", xbus_din, dt ^ 8'h0F);
      end else begin
        check(b ? "R8 io out" : "R3 io out", pin_out, dt);
        check(b ? "R8 io oe" : "R3 io oe", pin_oe, dd);
        check("R6 io pull", pin_pu, pl & ~dd);
        check("R7 din idle", xbus_din, 8'h00);
      end
      rd(A_DATA, v); check("R4 data readback", v, dt);
      rd(A_PULL, v); check("R4 pull readback", v, pl);
    end

    // R5 synchronizer latency
    @(negedge clk); mode = 3'd3; bus16 = 1'b0; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hC3;
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = A_PINS;
    @(negedge clk); #1 check("R5 pins after one edge", reg_rdata, 8'h00);
    @(negedge clk); #1 check("R5 pins after two edges", reg_rdata, 8'hC3);
    reg_sel = 1'b0;

    // R11 pin register write ignored, unmapped read
    wr(A_PINS, 8'h5A);
    rd(A_PINS, v); check("R11 pins write ignored", v, 8'hC3);
    rd(16'h1234, v); check("R11 unmapped read", v, 8'h00);

    // R10 manual reset and software standby hold
    wr(A_DIR, 8'h0F); wr(A_DATA, 8'h96);
    @(negedge clk); rst_manual = 1'b1;
    wr(A_DATA, 8'h11); wr(A_DIR, 8'hF0);
    @(negedge clk); rst_manual = 1'b0;
    #1 check("R10 manual keeps dir", pin_oe, 8'h0F);
    rd(A_DATA, v); check("R10 manual keeps data", v, 8'h96);
    @(negedge clk); stby_sw = 1'b1;
    wr(A_PULL, 8'hEE); wr(A_DATA, 8'h22);
    @(negedge clk); stby_sw = 1'b0;
    rd(A_DATA, v); check("R10 sw standby keeps data", v, 8'h96);
    rd(A_PULL, v); check("R10 sw standby keeps pull", v, 8'h55);

    // R9 hardware standby clears
    wr(A_PULL, 8'h3C);
    @(negedge clk); stby_hw = 1'b1;
    @(negedge clk); stby_hw = 1'b0;
    #1 check("R9 hw standby dir", pin_oe, 8'h00);
    rd(A_DATA, v); check("R9 hw standby data", v, 8'h00);
    rd(A_PULL, v); check("R9 hw standby pull", v, 8'h00);

    // R1 power-on reset mid-run
    wr(A_DIR, 8'hFF); wr(A_DATA, 8'h77);
    @(negedge clk); rst_por_n = 1'b0;
    #1 check("R1 por async oe", pin_oe, 8'h00);
    @(negedge clk); rst_por_n = 1'b1;
    rd(A_DATA, v); check("R1 por data cleared", v, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule